// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block is the coherence controller of one write-back cache on a shared atomic bus, using a write-invalidate protocol. It keeps a small direct-mapped array of lines. Each line holds a tag, one data word and a state: Invalid, Shared or Modified. The processor side issues one read or write at a time and holds it until `cpu_ready_o` completes it. Hits finish in the cycle they are presented. Misses, and writes to Shared lines, request the bus. When the grant arrives they complete in that cycle.

On the same line array, a snoop side watches every bus transaction that carries another cache's ID. A Modified owner supplies its line when a foreign transaction hits it. The supply pulse also writes the line back and tells memory to abort its own response. After a foreign read miss the owner drops to Shared. After a foreign write miss or invalidate it drops to Invalid.

The cache changes no state until it holds the bus. While a request waits for the grant, foreign snoops are applied first, and the request is decided again from the updated line. A dirty victim with another tag is written back in a granted cycle of its own, before the miss goes out.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. The first access to any address is a miss: a read drives bus command 01 in its grant cycle.
- R2: A read to a line held Shared or Modified with a matching tag, or a write to a Modified line with a matching tag, raises `cpu_ready_o` in the cycle the request is presented, with `bus_req_o` low. A read returns the stored word.
- R3: Bus commands are 00 none, 01 read miss, 10 write miss, 11 invalidate. A read miss installs the line Shared. A write miss installs it Modified. A write to a Shared line with a matching tag issues 11 and leaves the line Modified.
- R4: A miss completes in the cycle it is granted. `cpu_ready_o` is high in that cycle, and for a read `cpu_rdata_o` carries `bus_fill_i`.
- R5: A foreign read miss (01) that hits a Modified line raises `snp_supply_o` in the same cycle, with the line word on `snp_data_o`. The line becomes Shared, so a later local write to it issues 11.
- R6: A foreign write miss (10) or invalidate (11) that hits a held line makes it Invalid. If the line was Modified, `snp_supply_o` carries its word in the same cycle.
- R7: A transaction whose `snp_id_i` equals the cache's own ID changes no line and never raises `snp_supply_o`.
- R8: A miss whose index holds a Modified line with another tag first takes a granted cycle with `wb_o` high, the victim's address and word, and bus command 00. The miss transaction follows in a later grant.
- R9: No line state changes except in a granted cycle or under a foreign snoop. A foreign transaction that hits the block while the request waits is applied first. The request is then decided again, so a pending upgrade that loses its Shared copy becomes a write miss (10).
- R10: A foreign transaction on the same index as the pending request holds `cpu_ready_o` low in that cycle. A hit completes in a later cycle.
- R11: The caches stay coherent. At most one holds a block Modified, and a Modified holder excludes Shared holders, so every read returns the last value written to that address by any cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request pending, held until ready |
| cpu_we_i | input | 1 | 1 write, 0 read |
| cpu_addr_i | input | ADDR_W | Word address, index in the low IDX_W bits |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | Command driven in the granted cycle |
| bus_addr_o | output | ADDR_W | Address of the transaction or write-back |
| bus_id_o | output | ID_W | Requester ID of this cache |
| bus_fill_i | input | DATA_W | Line word returned for a miss |
| wb_o | output | 1 | Victim write-back in the granted cycle |
| wb_addr_o | output | ADDR_W | Victim address |
| wb_data_o | output | DATA_W | Victim word |
| snp_cmd_i | input | 2 | Command on the bus |
| snp_addr_i | input | ADDR_W | Address on the bus |
| snp_id_i | input | ID_W | Requester ID on the bus |
| snp_supply_o | output | 1 | Dirty line supplied, memory response aborted |
| snp_data_o | output | DATA_W | Supplied word |

## Verification
The assertions check the following on every cycle. A hit never coexists with a bus request. Each granted miss completes in its grant cycle. A supply only answers a foreign transaction. A victim write-back only occupies a granted cycle with no command. A foreign transaction on the request's index holds off completion. No line state changes outside a granted or foreign-snooped cycle. Two controllers on a shared bus model are compared against a bench reference of both caches. That comparison covers the bus command, write-back and supply of each request, and the value every read returns. The ordering cases can only be shown by those scenarios: the lost upgrade that restarts as a write miss, the one-cycle hit deferral behind a foreign read, and the dirty victim reaching memory.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_M = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'b00,
    BUS_RD   = 2'b01,
    BUS_WR   = 2'b10,
    BUS_INV  = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [TAG_W-1:0]  a_tag_o,
  output line_st_e          a_st_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [TAG_W-1:0]  b_tag_o,
  output line_st_e          b_st_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              s_we_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  line_st_e          s_st_i,
  input  logic              c_we_i,
  input  logic [IDX_W-1:0]  c_idx_i,
  input  logic [TAG_W-1:0]  c_tag_i,
  input  line_st_e          c_st_i,
  input  logic              c_dwe_i,
  input  logic [DATA_W-1:0] c_data_i,
  output logic [2*(1<<IDX_W)-1:0] st_vec_o
);
  localparam int NLINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_arr  [NLINES];
  line_st_e          st_arr   [NLINES];
  logic [DATA_W-1:0] data_arr [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [TAG_W-1:0]  tag_r;
    line_st_e          st_r;
    logic [DATA_W-1:0] data_r;
    logic              s_sel, c_sel;

    assign s_sel = s_we_i && (s_idx_i == IDX_W'(g));
    assign c_sel = c_we_i && (c_idx_i == IDX_W'(g));

    // snoop port wins; the processor port never targets a snooped index
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_r  <= '0;
        st_r   <= ST_I;
        data_r <= '0;
      end else if (s_sel) begin
        st_r <= s_st_i;
      end else if (c_sel) begin
        tag_r <= c_tag_i;
        st_r  <= c_st_i;
        if (c_dwe_i) data_r <= c_data_i;
      end
    end

    assign tag_arr[g]         = tag_r;
    assign st_arr[g]          = st_r;
    assign data_arr[g]        = data_r;
    assign st_vec_o[2*g +: 2] = st_r;
  end

  assign a_tag_o  = tag_arr[a_idx_i];
  assign a_st_o   = st_arr[a_idx_i];
  assign a_data_o = data_arr[a_idx_i];
  assign b_tag_o  = tag_arr[b_idx_i];
  assign b_st_o   = st_arr[b_idx_i];
  assign b_data_o = data_arr[b_idx_i];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int              TAG_W  = 4,
  parameter int              DATA_W = 8,
  parameter int              ID_W   = 1,
  parameter logic [ID_W-1:0] MY_ID  = '0
) (
  input  logic [1:0]        cmd_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              fvld_o,
  output logic              we_o,
  output line_st_e          st_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] data_o
);
  logic hit, dirty, is_rd;

  always_comb begin
    fvld_o   = (cmd_i != BUS_NONE) && (id_i != MY_ID);
    hit      = fvld_o && (line_tag_i == tag_i) && (line_st_i != ST_I);
    dirty    = line_st_i == ST_M;
    is_rd    = cmd_i == BUS_RD;
    supply_o = hit && dirty;
    data_o   = line_data_i;
    we_o     = hit && (!is_rd || dirty);
    st_o     = is_rd ? ST_S : ST_I;
  end
endmodule

// File: rtl/msi_req_unit.sv
module msi_req_unit
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [TAG_W-1:0]        line_tag_i,
  input  line_st_e                line_st_i,
  input  logic [DATA_W-1:0]       line_data_i,
  input  logic                    gnt_i,
  input  logic [DATA_W-1:0]       fill_i,
  input  logic                    conflict_i,
  output logic                    bus_req_o,
  output logic [1:0]              cmd_o,
  output logic [TAG_W+IDX_W-1:0]  addr_o,
  output logic                    wb_o,
  output logic [TAG_W+IDX_W-1:0]  wb_addr_o,
  output logic [DATA_W-1:0]       wb_data_o,
  output logic                    ready_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    st_we_o,
  output logic [TAG_W-1:0]        st_tag_o,
  output line_st_e                st_o,
  output logic                    dwe_o,
  output logic [DATA_W-1:0]       data_o
);
  logic     tag_eq, present, hit, victim, grant, hit_go;
  bus_cmd_e miss_cmd;

  // decided afresh every cycle, so a snooped change restarts the request
  always_comb begin
    tag_eq    = line_tag_i == tag_i;
    present   = tag_eq && (line_st_i != ST_I);
    hit       = req_i && present && (!we_i || line_st_i == ST_M);
    victim    = req_i && !hit && (line_st_i == ST_M) && !tag_eq;
    miss_cmd  = (present && we_i) ? BUS_INV : (we_i ? BUS_WR : BUS_RD);
    bus_req_o = req_i && !hit;
    grant     = bus_req_o && gnt_i;
    hit_go    = hit && !conflict_i;
    ready_o   = hit_go || (grant && !victim);
    cmd_o     = (grant && !victim) ? miss_cmd : BUS_NONE;
    wb_addr_o = {line_tag_i, idx_i};
    addr_o    = victim ? wb_addr_o : {tag_i, idx_i};
    wb_o      = grant && victim;
    wb_data_o = line_data_i;
    rdata_o   = hit ? line_data_i : fill_i;
    st_we_o   = grant || (hit_go && we_i);
    st_tag_o  = victim ? line_tag_i : tag_i;
    st_o      = victim ? ST_I : (we_i ? ST_M : ST_S);
    dwe_o     = !victim;
    data_o    = we_i ? wdata_i : fill_i;
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int              ADDR_W = 6,
  parameter int              IDX_W  = 2,
  parameter int              DATA_W = 8,
  parameter int              ID_W   = 1,
  parameter logic [ID_W-1:0] MY_ID  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [ID_W-1:0]   bus_id_o,
  input  logic [DATA_W-1:0] bus_fill_i,
  output logic              wb_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [ID_W-1:0]   snp_id_i,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int NLINES = 1 << IDX_W;

  logic [IDX_W-1:0]    cpu_idx, snp_idx;
  logic [TAG_W-1:0]    cpu_tag, snp_tag;
  logic [TAG_W-1:0]    a_tag, b_tag, c_tag;
  line_st_e            a_st, b_st, c_st, s_st;
  logic [DATA_W-1:0]   a_data, b_data, c_data;
  logic                s_we, c_we, c_dwe, fsnp_vld, conflict;
  logic [2*NLINES-1:0] st_vec;

  assign cpu_idx  = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag  = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx  = snp_addr_i[IDX_W-1:0];
  assign snp_tag  = snp_addr_i[ADDR_W-1:IDX_W];
  assign conflict = fsnp_vld && (snp_idx == cpu_idx);
  assign bus_id_o = MY_ID;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .a_idx_i(cpu_idx), .a_tag_o(a_tag), .a_st_o(a_st), .a_data_o(a_data),
    .b_idx_i(snp_idx), .b_tag_o(b_tag), .b_st_o(b_st), .b_data_o(b_data),
    .s_we_i(s_we), .s_idx_i(snp_idx), .s_st_i(s_st),
    .c_we_i(c_we), .c_idx_i(cpu_idx), .c_tag_i(c_tag), .c_st_i(c_st),
    .c_dwe_i(c_dwe), .c_data_i(c_data), .st_vec_o(st_vec)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
    .cmd_i(snp_cmd_i), .id_i(snp_id_i), .tag_i(snp_tag),
    .line_tag_i(b_tag), .line_st_i(b_st), .line_data_i(b_data),
    .fvld_o(fsnp_vld), .we_o(s_we), .st_o(s_st),
    .supply_o(snp_supply_o), .data_o(snp_data_o)
  );

  msi_req_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
    .req_i(cpu_req_i), .we_i(cpu_we_i), .tag_i(cpu_tag), .idx_i(cpu_idx),
    .wdata_i(cpu_wdata_i), .line_tag_i(a_tag), .line_st_i(a_st), .line_data_i(a_data),
    .gnt_i(bus_gnt_i), .fill_i(bus_fill_i), .conflict_i(conflict),
    .bus_req_o(bus_req_o), .cmd_o(bus_cmd_o), .addr_o(bus_addr_o),
    .wb_o(wb_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
    .ready_o(cpu_ready_o), .rdata_o(cpu_rdata_o),
    .st_we_o(c_we), .st_tag_o(c_tag), .st_o(c_st), .dwe_o(c_dwe), .data_o(c_data)
  );
endmodule

// File: rtl/msi_snoop_chk.sv
module msi_snoop_chk
  import msi_pkg::*;
#(
  parameter int              IDX_W = 2,
  parameter int              ID_W  = 1,
  parameter logic [ID_W-1:0] MY_ID = '0,
  parameter int              ST_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_ready_o,
  input logic             bus_req_o,
  input logic             bus_gnt_i,
  input logic [1:0]       bus_cmd_o,
  input logic             wb_o,
  input logic             snp_supply_o,
  input logic [1:0]       snp_cmd_i,
  input logic [ID_W-1:0]  snp_id_i,
  input logic             fsnp_vld,
  input logic [IDX_W-1:0] snp_idx,
  input logic [IDX_W-1:0] cpu_idx,
  input logic [ST_W-1:0]  st_vec
);
  assert_hit_nobus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && !bus_gnt_i |-> !bus_req_o);

  assert_grant_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i && bus_req_o && (bus_cmd_o != BUS_NONE) |-> cpu_ready_o);

  assert_supply_foreign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> (snp_cmd_i != BUS_NONE) && (snp_id_i != MY_ID));

  assert_wb_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> bus_gnt_i && (bus_cmd_o == BUS_NONE) && !cpu_ready_o);

  assert_state_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(st_vec) |-> $past(bus_gnt_i && bus_req_o) || $past(fsnp_vld));

  assert_snoop_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsnp_vld && (snp_idx == cpu_idx) |-> !cpu_ready_o);
endmodule

bind msi_snoop_ctrl msi_snoop_chk #(
  .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID), .ST_W(2*NLINES)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_ready_o(cpu_ready_o), .bus_req_o(bus_req_o),
  .bus_gnt_i(bus_gnt_i), .bus_cmd_o(bus_cmd_o), .wb_o(wb_o), .snp_supply_o(snp_supply_o),
  .snp_cmd_i(snp_cmd_i), .snp_id_i(snp_id_i), .fsnp_vld(fsnp_vld),
  .snp_idx(snp_idx), .cpu_idx(cpu_idx), .st_vec(st_vec)
);

// File: tb/msi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic       req [2];
  logic       we  [2];
  logic [5:0] addr[2];
  logic [7:0] wd  [2];
  logic       rdy [2];
  logic [7:0] rd  [2];
  logic       breq[2];
  logic       gnt [2];
  logic [1:0] bcmd[2];
  logic [5:0] badr[2];
  logic       bid [2];
  logic       wbv [2];
  logic [5:0] wba [2];
  logic [7:0] wbd [2];
  logic       sup [2];
  logic [7:0] sdat[2];
  logic [1:0] bus_cmd;
  logic [5:0] bus_addr;
  logic       bus_id;
  logic [7:0] fill;
  logic [7:0] mem [64];

  msi_snoop_ctrl #(.MY_ID(1'b0)) dut_i (
    .clk_i, .rst_ni, .cpu_req_i(req[0]), .cpu_we_i(we[0]), .cpu_addr_i(addr[0]),
    .cpu_wdata_i(wd[0]), .cpu_ready_o(rdy[0]), .cpu_rdata_o(rd[0]),
    .bus_req_o(breq[0]), .bus_gnt_i(gnt[0]), .bus_cmd_o(bcmd[0]), .bus_addr_o(badr[0]),
    .bus_id_o(bid[0]), .bus_fill_i(fill), .wb_o(wbv[0]), .wb_addr_o(wba[0]),
    .wb_data_o(wbd[0]), .snp_cmd_i(bus_cmd), .snp_addr_i(bus_addr), .snp_id_i(bus_id),
    .snp_supply_o(sup[0]), .snp_data_o(sdat[0]));

  msi_snoop_ctrl #(.MY_ID(1'b1)) peer_i (
    .clk_i, .rst_ni, .cpu_req_i(req[1]), .cpu_we_i(we[1]), .cpu_addr_i(addr[1]),
    .cpu_wdata_i(wd[1]), .cpu_ready_o(rdy[1]), .cpu_rdata_o(rd[1]),
    .bus_req_o(breq[1]), .bus_gnt_i(gnt[1]), .bus_cmd_o(bcmd[1]), .bus_addr_o(badr[1]),
    .bus_id_o(bid[1]), .bus_fill_i(fill), .wb_o(wbv[1]), .wb_addr_o(wba[1]),
    .wb_data_o(wbd[1]), .snp_cmd_i(bus_cmd), .snp_addr_i(bus_addr), .snp_id_i(bus_id),
    .snp_supply_o(sup[1]), .snp_data_o(sdat[1]));

  // fixed priority arbiter: cache 0 wins
  always_comb begin
    gnt[0]   = breq[0];
    gnt[1]   = breq[1] && !breq[0];
    bus_cmd  = gnt[0] ? bcmd[0] : (gnt[1] ? bcmd[1] : 2'b00);
    bus_addr = gnt[0] ? badr[0] : (gnt[1] ? badr[1] : 6'd0);
    bus_id   = gnt[0] ? bid[0]  : (gnt[1] ? bid[1]  : 1'b0);
    fill     = sup[0] ? sdat[0] : (sup[1] ? sdat[1] : mem[bus_addr]);
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (wbv[c]) mem[wba[c]] <= wbd[c];
        if (sup[c]) mem[bus_addr] <= sdat[c];
      end
    end
  end

  int checks = 0, errors = 0;
  int mtag[2][4];
  int mst [2][4];
  logic [7:0] gold[64];
  int   r_cmd[2], r_cyc[2];
  bit   r_wb[2], r_sup[2];
  logic [7:0] r_rd[2];

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // reference of both caches: 0 I, 1 S, 2 M
  task automatic predict(int c, bit w, int tg, int ix, output int cmd, output bit wb, output bit sp);
    int o = 1 - c;
    bit present = (mst[c][ix] != 0) && (mtag[c][ix] == tg);
    cmd = 0; wb = 0; sp = 0;
    if (present && (!w || mst[c][ix] == 2)) return;
    if (mst[c][ix] == 2 && mtag[c][ix] != tg) begin
      wb = 1;
      mst[c][ix] = 0;
    end
    cmd = (present && w) ? 3 : (w ? 2 : 1);
    if (mst[o][ix] != 0 && mtag[o][ix] == tg) begin
      if (mst[o][ix] == 2) sp = 1;
      if (cmd == 1) mst[o][ix] = 1;
      else mst[o][ix] = 0;
    end
    mtag[c][ix] = tg;
    mst[c][ix]  = w ? 2 : 1;
  endtask

  task automatic do_op(int c, bit w, logic [5:0] a, logic [7:0] d);
    bit done = 0;
    @(negedge clk_i);
    req[c] = 1'b1; we[c] = w; addr[c] = a; wd[c] = d;
    r_cmd[c] = 0; r_wb[c] = 0; r_sup[c] = 0; r_cyc[c] = 0;
    for (int k = 0; k < 50 && !done; k++) begin
      #1;
      r_cyc[c]++;
      if (gnt[c] && wbv[c]) r_wb[c] = 1;
      if (gnt[c] && bcmd[c] != 2'b00) begin
        r_cmd[c] = int'(bcmd[c]);
        if (sup[1-c]) r_sup[c] = 1;
      end
      if (rdy[c]) begin
        r_rd[c] = rd[c];
        done = 1;
      end else begin
        @(negedge clk_i);
      end
    end
    if (!done) chk(0, "R4 op timeout", 0, 1);
    @(posedge clk_i);
    #1 req[c] = 1'b0;
  endtask

  task automatic run_op(int c, bit w, int tg, int ix, logic [7:0] d);
    int ec; bit ew, es;
    logic [5:0] a = {tg[3:0], ix[1:0]};
    predict(c, w, tg, ix, ec, ew, es);
    do_op(c, w, a, d);
    chk(r_cmd[c] == ec, ec == 0 ? "R2 R7 cmd" : "R3 cmd", r_cmd[c], ec);
    chk(r_wb[c] == ew, "R8 writeback", int'(r_wb[c]), int'(ew));
    chk(r_sup[c] == es, ec == 1 ? "R5 supply" : "R6 supply", int'(r_sup[c]), int'(es));
    chk(r_cyc[c] == ((ec == 0) ? 1 : 1 + int'(ew)), ec == 0 ? "R2 latency" : "R4 latency",
        r_cyc[c], (ec == 0) ? 1 : 1 + int'(ew));
    if (!w) chk(r_rd[c] == gold[a], "R11 read data", int'(r_rd[c]), int'(gold[a]));
    else gold[a] = d;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e0, e1; bit w0, w1, s0, s1;
    void'($urandom(32'd4242));
    for (int c = 0; c < 2; c++) begin
      req[c] = 0; we[c] = 0; addr[c] = '0; wd[c] = '0;
      for (int i = 0; i < 4; i++) begin mtag[c][i] = 0; mst[c][i] = 0; end
    end
    for (int i = 0; i < 64; i++) gold[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!rdy[0] && !breq[0] && !sup[0], "R1 reset quiet", int'(rdy[0] | breq[0] | sup[0]), 0);
    chk(!rdy[1] && !breq[1] && !sup[1], "R1 reset quiet peer", int'(rdy[1] | breq[1] | sup[1]), 0);

    // directed sequence
    run_op(0, 0, 1, 0, 8'h00);
    chk(r_cmd[0] == 1, "R1 first read misses", r_cmd[0], 1);
    run_op(0, 1, 1, 0, 8'hA1);   // upgrade S -> M
    run_op(0, 0, 1, 0, 8'h00);   // hit in M after own invalidate
    run_op(1, 0, 1, 0, 8'h00);   // owner supplies, drops to S
    run_op(0, 1, 1, 0, 8'hA2);   // S again: invalidate
    chk(r_cmd[0] == 3, "R5 owner downgraded to S", r_cmd[0], 3);
    run_op(1, 0, 1, 0, 8'h00);
    run_op(1, 1, 1, 0, 8'hB1);
    run_op(0, 0, 1, 0, 8'h00);   // was invalidated, peer supplies
    run_op(0, 1, 2, 1, 8'hC1);   // write miss
    run_op(1, 1, 2, 1, 8'hC2);   // write miss, dirty peer supplies
    chk(r_sup[1] == 1, "R6 write miss on dirty peer", int'(r_sup[1]), 1);
    run_op(1, 0, 0, 1, 8'h00);   // dirty victim written back first
    chk(r_wb[1] == 1, "R8 victim writeback", int'(r_wb[1]), 1);
    run_op(0, 0, 2, 1, 8'h00);   // value from memory after writeback

    // R9: both hold S, both write; cache 0 wins, cache 1 restarts as write miss
    run_op(0, 0, 1, 2, 8'h00);
    run_op(1, 0, 1, 2, 8'h00);
    predict(0, 1, 1, 2, e0, w0, s0);
    predict(1, 1, 1, 2, e1, w1, s1);
    fork
      do_op(0, 1, 6'b0001_10, 8'h5A);
      do_op(1, 1, 6'b0001_10, 8'h6B);
    join
    chk(r_cmd[0] == e0, "R9 winner invalidates", r_cmd[0], e0);
    chk(r_cmd[1] == e1, "R9 loser restarts as write miss", r_cmd[1], e1);
    chk(r_cyc[1] == 2, "R9 loser waits one grant", r_cyc[1], 2);
    chk(r_sup[1] == s1, "R9 supply to loser", int'(r_sup[1]), int'(s1));
    gold[6'b0001_10] = 8'h6B;
    run_op(0, 0, 1, 2, 8'h00);
    run_op(1, 0, 1, 2, 8'h00);

    // R10: owner read hit deferred behind peer read of same index
    run_op(0, 1, 2, 3, 8'h77);
    predict(1, 0, 2, 3, e1, w1, s1);
    predict(0, 0, 2, 3, e0, w0, s0);
    fork
      do_op(0, 0, 6'b0010_11, 8'h00);
      do_op(1, 0, 6'b0010_11, 8'h00);
    join
    chk(r_cyc[0] == 2, "R10 hit held one cycle", r_cyc[0], 2);
    chk(r_rd[0] == 8'h77, "R10 deferred hit data", int'(r_rd[0]), 8'h77);
    chk(r_cmd[0] == e0, "R10 deferred op is a hit", r_cmd[0], e0);
    chk(r_sup[1] == 1, "R5 supply on concurrent read", int'(r_sup[1]), 1);
    chk(r_rd[1] == 8'h77, "R11 peer read data", int'(r_rd[1]), 8'h77);

    // constrained random traffic
    for (int n = 0; n < 500; n++) begin
      int c  = int'($urandom % 2);
      bit w  = bit'($urandom % 2);
      int tg = int'($urandom % 3);
      int ix = int'($urandom % 4);
      run_op(c, w, tg, ix, 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule